// File: doc/BRIEF.md
# Phase-Related Clock Downscaling Gearbox

The block accepts a wide word on a slow clock and replays it on a fast clock as a burst of narrower units, one unit per fast cycle. The fast clock runs at exactly `RATIO` times the slow clock, where `RATIO = IN_W / OUT_W`. The two clocks are phase aligned, so every slow rising edge falls on a fast rising edge. No FIFO, handshake or synchronizer is needed.

On each slow edge with the valid strobe high, the slow side latches the word and flips a toggle bit. The fast side sees the toggle change on the first fast cycle after that slow edge. A modulo-`RATIO` counter then restarts and walks through the units. Units are emitted lowest first by default, or highest first when `BIG_ENDIAN` is set. `IN_REG` adds one register stage on the slow side, and `OUT_REG` adds one on the fast side.

Top module: `gbx_down_dc`

## Requirements
- R1: While `rst_ni` is low, and afterwards until the first accepted word reaches the output, `valid_o` and `first_o` are 0.
- R2: With `BIG_ENDIAN`=0, the k-th fast cycle of a burst (k = 0 to RATIO-1) carries bits [k*OUT_W +: OUT_W] of the accepted word.
- R3: With `BIG_ENDIAN`=1, the k-th fast cycle of a burst carries bits [(RATIO-1-k)*OUT_W +: OUT_W] of the accepted word.
- R4: Each accepted word gives exactly RATIO consecutive fast cycles with `valid_o` high. Words on back-to-back slow edges give an unbroken valid stream. A slow edge with `valid_i` low produces no output.
- R5: `first_o` is high only on the first cycle of each burst, and only together with `valid_o`.
- R6: With both register options off, the first unit of a word captured on a slow edge is on the output just after the next fast edge. `IN_REG`=1 adds RATIO fast cycles, and `OUT_REG`=1 adds one fast cycle, in any combination.
- R7: `data_i` and `valid_i` are sampled only on slow rising edges. Values they hold between slow edges have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | Slow clock; samples the wide word |
| clk_fast_i | input | 1 | Fast clock at RATIO times the slow clock, phase aligned |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| data_i | input | IN_W | Wide input word |
| valid_i | input | 1 | Input word valid, sampled on the slow edge |
| data_o | output | OUT_W | Current output unit |
| valid_o | output | 1 | Output unit valid |
| first_o | output | 1 | Marks the first unit of a burst |

## Verification
The assertions assume three things about the inputs: the fast clock has exactly RATIO rising edges per slow period, one of them coincides with each slow rising edge, and reset is released in both domains together. Only under these conditions does the toggle change exactly once per burst, and only then is a burst never cut short by the next start. The stimulus generates both clocks from one process, with the slow clock derived from a fast-edge phase counter, so the alignment holds by construction. Between slow edges it fills the inputs with junk, and it drops the valid strobe at irregular slow edges to exercise idle gaps.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/gbx_src_stage.sv
module gbx_src_stage #(
  parameter int unsigned IN_W   = 32,
  parameter bit          IN_REG = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IN_W-1:0] data_i,
  input  logic            valid_i,
  output logic [IN_W-1:0] word_o,
  output logic            tog_o
);
  logic [IN_W-1:0] d_s;
  logic            v_s;

  if (IN_REG) begin : g_in_reg
    logic [IN_W-1:0] d_q;
    logic            v_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_q <= '0;
        v_q <= 1'b0;
      end else begin
        d_q <= data_i;
        v_q <= valid_i;
      end
    end
    assign d_s = d_q;
    assign v_s = v_q;
  end else begin : g_in_wire
    assign d_s = data_i;
    assign v_s = valid_i;
  end

  logic [IN_W-1:0] word_q;
  logic            tog_q;

  // word is held for a full slow period; the toggle announces it to the fast side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      tog_q  <= 1'b0;
    end else if (v_s) begin
      word_q <= d_s;
      tog_q  <= ~tog_q;
    end
  end

  assign word_o = word_q;
  assign tog_o  = tog_q;

  p_tog_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_s |=> $stable(tog_q));
  p_tog_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_s |=> (tog_q != $past(tog_q)));
endmodule

// File: rtl/gbx_split.sv
module gbx_split
  import gbx_pkg::*;
#(
  parameter int unsigned IN_W       = 32,
  parameter int unsigned OUT_W      = 8,
  parameter bit          BIG_ENDIAN = 1'b0,
  parameter bit          OUT_REG    = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  word_i,
  input  logic             tog_i,
  output logic [OUT_W-1:0] unit_o,
  output logic             valid_o,
  output logic             first_o
);
  localparam int unsigned RATIO = IN_W / OUT_W;
  localparam int unsigned CW    = cnt_width(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic          tog_seen_q;
  logic          start;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [CW-1:0] pick;
  logic [CW-1:0] sel;
  logic [OUT_W-1:0] chunk;

  assign start = tog_i ^ tog_seen_q;
  assign pick  = start ? '0 : cnt_q;

  if (BIG_ENDIAN) begin : g_msb_first
    assign sel = LAST - pick;
  end else begin : g_lsb_first
    assign sel = pick;
  end

  assign chunk = word_i[sel*OUT_W +: OUT_W];

  logic [OUT_W-1:0] unit_q;
  logic             vld_q;
  logic             first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_seen_q <= 1'b0;
      cnt_q      <= '0;
      run_q      <= 1'b0;
      unit_q     <= '0;
      vld_q      <= 1'b0;
      first_q    <= 1'b0;
    end else begin
      tog_seen_q <= tog_i;
      if (start) begin
        unit_q  <= chunk;
        vld_q   <= 1'b1;
        first_q <= 1'b1;
        cnt_q   <= CW'(1);
        run_q   <= 1'b1;
      end else if (run_q) begin
        unit_q  <= chunk;
        vld_q   <= 1'b1;
        first_q <= 1'b0;
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        vld_q   <= 1'b0;
        first_q <= 1'b0;
      end
    end
  end

  if (OUT_REG) begin : g_out_reg
    logic [OUT_W-1:0] u_q;
    logic             v_q;
    logic             f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        u_q <= '0;
        v_q <= 1'b0;
        f_q <= 1'b0;
      end else begin
        u_q <= unit_q;
        v_q <= vld_q;
        f_q <= first_q;
      end
    end
    assign unit_o  = u_q;
    assign valid_o = v_q;
    assign first_o = f_q;
  end else begin : g_out_wire
    assign unit_o  = unit_q;
    assign valid_o = vld_q;
    assign first_o = first_q;
  end

  // checker-only run length counter
  logic [CW-1:0] run_mod_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_mod_q <= '0;
    else if (vld_q) run_mod_q <= (run_mod_q == LAST) ? '0 : run_mod_q + 1'b1;
    else run_mod_q <= '0;
  end

  always_comb begin
    a_cnt_range_r2: assert (!rst_ni || cnt_q <= LAST);
  end
  p_burst_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vld_q) |-> (run_mod_q == '0));
  p_first_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |-> vld_q);
  p_start_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (first_q && vld_q));
  p_no_overlap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> !run_q);
endmodule

// File: rtl/gbx_down_dc.sv
module gbx_down_dc #(
  parameter int unsigned IN_W       = 32,
  parameter int unsigned OUT_W      = 8,
  parameter bit          BIG_ENDIAN = 1'b0,
  parameter bit          IN_REG     = 1'b0,
  parameter bit          OUT_REG    = 1'b0
) (
  input  logic             clk_slow_i,
  input  logic             clk_fast_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  data_i,
  input  logic             valid_i,
  output logic [OUT_W-1:0] data_o,
  output logic             valid_o,
  output logic             first_o
);
  localparam int unsigned RATIO = IN_W / OUT_W;

  if ((IN_W % OUT_W) != 0 || RATIO < 2) begin : g_bad_ratio
    $error("gbx_down_dc: IN_W must be an integer multiple (>=2) of OUT_W");
  end

  logic [IN_W-1:0] word;
  logic            tog;

  gbx_src_stage #(
    .IN_W  (IN_W),
    .IN_REG(IN_REG)
  ) u_src (
    .clk_i  (clk_slow_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .valid_i(valid_i),
    .word_o (word),
    .tog_o  (tog)
  );

  gbx_split #(
    .IN_W      (IN_W),
    .OUT_W     (OUT_W),
    .BIG_ENDIAN(BIG_ENDIAN),
    .OUT_REG   (OUT_REG)
  ) u_split (
    .clk_i  (clk_fast_i),
    .rst_ni (rst_ni),
    .word_i (word),
    .tog_i  (tog),
    .unit_o (data_o),
    .valid_o(valid_o),
    .first_o(first_o)
  );
endmodule

// File: tb/sim_gbx_down_dc.sv
module sim_gbx_down_dc;
  localparam int R  = 4;
  localparam int OW = 8;
  localparam int IW = R * OW;
  localparam int NC = 5;
  localparam int SL = 64;

  logic clk_f, clk_s, rst_ni;
  logic [IW-1:0] din;
  logic          vin;
  logic [OW-1:0] dout_w [NC];
  logic          vo_w   [NC];
  logic          fo_w   [NC];

  int fe, ph;
  int n_run, n_fail;
  bit done;

  // configs: 0 none, 1 in, 2 out, 3 both, 4 in + msb-first
  function automatic bit cfg_in(int c);  return (c == 1 || c == 3 || c == 4); endfunction
  function automatic bit cfg_out(int c); return (c == 2 || c == 3); endfunction
  function automatic bit cfg_be(int c);  return (c == 4); endfunction

  for (genvar c = 0; c < NC; c++) begin : g_cfg
    gbx_down_dc #(
      .IN_W(IW), .OUT_W(OW),
      .BIG_ENDIAN(c == 4),
      .IN_REG(c == 1 || c == 3 || c == 4),
      .OUT_REG(c == 2 || c == 3)
    ) u0 (
      .clk_slow_i(clk_s), .clk_fast_i(clk_f), .rst_ni(rst_ni),
      .data_i(din), .valid_i(vin),
      .data_o(dout_w[c]), .valid_o(vo_w[c]), .first_o(fo_w[c])
    );
  end

  // both clocks from one process: 50 MHz fast, slow = fast / R, aligned rising edges
  initial begin
    clk_f = 1'b0; clk_s = 1'b0; ph = 0; fe = 0;
    forever begin
      #10;
      clk_f = ~clk_f;
      if (clk_f) begin
        fe = fe + 1;
        if (ph == 0) clk_s = 1'b1;
        else if (ph == R / 2) clk_s = 1'b0;
        ph = (ph + 1) % R;
      end
    end
  end

  logic [OW-1:0] ed [NC][SL];
  bit            ev [NC][SL];
  bit            ef [NC][SL];

  task automatic chk(bit ok, string req, int c, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cfg%0d t=%0t actual=%0h expected=%0h", req, c, $time, act, exp);
    end
  endtask

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  logic [31:0] lfsr;
  function automatic logic [31:0] step(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    lfsr = 32'h1bad_cafe;
    rst_ni = 1'b0; din = '0; vin = 1'b0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < SL; s++) begin ev[c][s] = 0; ef[c][s] = 0; ed[c][s] = '0; end

    // R1: outputs idle during reset
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_f);
      din = step(lfsr); vin = 1'b1; lfsr = step(lfsr);
      for (int c = 0; c < NC; c++) begin
        chk(vo_w[c] == 1'b0, "R1 valid in reset", c, vo_w[c], 0);
        chk(fo_w[c] == 1'b0, "R1 first in reset", c, fo_w[c], 0);
      end
    end
    @(negedge clk_f);
    vin = 1'b0;
    rst_ni = 1'b1;

    for (int cyc = 0; cyc < 2400; cyc++) begin
      @(negedge clk_f);
      // compare outputs after fast edge fe with the schedule
      for (int c = 0; c < NC; c++) begin
        int s;
        s = fe % SL;
        // R4/R6: valid timing; R1 covers the idle lead-in
        chk(vo_w[c] == ev[c][s], "R4 R6 R1 valid", c, vo_w[c], ev[c][s]);
        chk(fo_w[c] == ef[c][s], "R5 first", c, fo_w[c], ef[c][s]);
        if (ev[c][s]) begin
          if (cfg_be(c)) chk(dout_w[c] == ed[c][s], "R3 R6 R7 data", c, dout_w[c], ed[c][s]);
          else           chk(dout_w[c] == ed[c][s], "R2 R6 R7 data", c, dout_w[c], ed[c][s]);
        end
        ev[c][s] = 0; ef[c][s] = 0;
      end
      lfsr = step(lfsr);
      if (ph == 0) begin
        // next fast edge is a slow edge: real stimulus
        logic v;
        v = (lfsr[3:0] != 4'h0) && !(cyc > 1200 && cyc < 1240);
        din = step(lfsr);
        vin = v;
        if (v) begin
          for (int c = 0; c < NC; c++) begin
            int lat;
            lat = 1 + (cfg_in(c) ? R : 0) + (cfg_out(c) ? 1 : 0);
            for (int i = 0; i < R; i++) begin
              int s, idx;
              s = (fe + 1 + lat + i) % SL;
              idx = cfg_be(c) ? (R - 1 - i) : i;
              ev[c][s] = 1;
              ef[c][s] = (i == 0);
              ed[c][s] = din[idx*OW +: OW];
            end
          end
        end
      end else begin
        // R7: junk between slow edges must be ignored
        din = ~step(lfsr);
        vin = lfsr[7];
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule